// File: doc/BRIEF.md
# Flash Program/Erase Error-Protection Controller

This block sits beside an on-chip flash controller and keeps runaway or illegal processor activity from damaging the array while a program or erase operation is underway. Software sets mode bits through a small register write port: program, erase, program-verify and erase-verify, plus a block-enable register. The block turns those bits into permission outputs that the flash sequencer obeys. If the processor reads or fetches from flash, takes an exception, or executes a sleep or standby instruction while program or erase mode is active, the block latches a sticky error flag. It then withdraws program and erase permission on the very next clock edge.

Once the flag is set, the register contents are kept, but program and erase mode cannot be re-entered. Only the verify modes stay usable. The flag is cleared only by the asynchronous reset or by the hardware standby input, and both of these also clear every register. A power-down request clears the mode and block-enable registers but leaves the flag untouched. When power-down ends, the block returns to the state the flag implies.

Top module: `flash_guard`

## Requirements
- R1: After reset the error flag is 0, both registers read 0, read and verify are permitted, and program and erase are not permitted.
- R2: A write with `wr_sel`=0 loads the mode register from `wr_data[3:0]`: bit 0 is program, bit 1 is erase, bit 2 is program-verify and bit 3 is erase-verify. A write with `wr_sel`=1 loads the block-enable register from the whole of `wr_data`. In normal operation `ok_prog` and `ok_erase` follow the stored program and erase bits, and `vfy_act` is high when either verify bit is set.
- R3: A mode write with bit 0 and bit 1 both set stores program as 1 and erase as 0, so program mode is entered and the erase request is dropped.
- R4: A flash read or fetch strobe, an exception-entry strobe or a sleep/standby strobe, sampled at a clock edge while program or erase is permitted, sets the error flag at that edge. `ok_prog` and `ok_erase` are 0 in the same cycle in which the flag first reads 1.
- R5: The same strobes have no effect on the error flag when neither program nor erase is permitted.
- R6: Setting the error flag leaves both register contents unchanged.
- R7: While the error flag is 1 and the block is not powered down, `ok_read`, `ok_prog` and `ok_erase` are 0 whatever is written to the mode bits. `ok_verify` is 1, the mode register stays writable, and `vfy_act` follows the verify bits.
- R8: The error flag is cleared only by `rst_n` low or by `hw_stby` high. `hw_stby` clears both registers and the flag at the next edge, and every permission output is 0 while it is high.
- R9: The clock edge on which `pd_req` first goes high clears both registers and keeps the flag. While powered down, all permission outputs are 0 and register writes are ignored.
- R10: When `pd_req` falls, the block leaves power-down at the next edge. It returns to normal permissions if the flag is 0, and to the error permissions of R7 if the flag is 1.
- R11: Event strobes during power-down do not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; clears all state synchronously |
| pd_req | input | 1 | Power-down request, level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mode register, 1 selects the block-enable register |
| wr_data | input | BLK_W | Write data |
| ev_fetch | input | 1 | Flash read, vector read or instruction fetch strobe |
| ev_exc | input | 1 | Exception-entry strobe (reset excluded) |
| ev_sleep | input | 1 | Sleep or standby instruction strobe |
| ok_read | output | 1 | Flash read permitted |
| ok_verify | output | 1 | Verify read permitted |
| ok_prog | output | 1 | Programming permitted (high-voltage program enable) |
| ok_erase | output | 1 | Erasing permitted (high-voltage erase enable) |
| vfy_act | output | 1 | A verify mode is selected and permitted |
| err_flag | output | 1 | Sticky error flag |
| ctrl_q | output | 4 | Mode register contents |
| blk_q | output | BLK_W | Block-enable register contents |

## Verification
The assertions assume that `rst_n` is released away from the clock edge, and that `hw_stby` and `pd_req` are held for whole cycles. The register-retention property also assumes that no register write lands on the same edge as the violating event, because a write on that edge would legitimately change the registers. The bench drives every input on the falling edge and holds each for one full cycle. It issues each event strobe alone, in cycles with no write, so that every change it observes at the outputs has a single cause.

// File: rtl/fg_pkg.sv
package fg_pkg;

  localparam int CTRL_W = 4;

  // bit 0 program, bit 1 erase, bit 2 program-verify, bit 3 erase-verify
  typedef struct packed {
    logic everify;
    logic pverify;
    logic erase;
    logic prog;
  } ctrl_t;

  typedef enum logic [0:0] {
    PW_RUN  = 1'b0,
    PW_DOWN = 1'b1
  } pwr_t;

  typedef struct packed {
    logic rd;
    logic vf;
    logic pr;
    logic er;
  } permit_t;

  // Program wins over erase when both are requested together.
  function automatic ctrl_t f_accept(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c = ctrl_t'(w);
    if (c.prog) c.erase = 1'b0;
    return c;
  endfunction

  // Permissions from the power state, standby, error flag and mode bits.
  function automatic permit_t f_permit(input logic down, input logic stby,
                                       input logic err, input ctrl_t c);
    permit_t p;
    p = '0;
    if (!stby && !down) begin
      p.vf = 1'b1;
      if (!err) begin
        p.rd = 1'b1;
        p.pr = c.prog;
        p.er = c.erase;
      end
    end
    return p;
  endfunction

  // An operation is in progress when program or erase is permitted.
  function automatic logic f_busy(input permit_t p);
    return p.pr | p.er;
  endfunction

endpackage

// File: rtl/fg_ctrl_regs.sv
module fg_ctrl_regs
  import fg_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             pd_req,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BLK_W-1:0] wr_data,
  output ctrl_t            ctrl_q,
  output logic [BLK_W-1:0] blk_q,
  output logic             down
);

  pwr_t pw_q;
  logic pd_enter;
  logic pd_leave;
  logic wr_ctrl;
  logic wr_blk;

  assign down     = (pw_q == PW_DOWN);
  assign pd_enter = pd_req && !down;
  assign pd_leave = !pd_req && down;
  assign wr_ctrl  = wr_en && !wr_sel && !down && !pd_enter;
  assign wr_blk   = wr_en &&  wr_sel && !down && !pd_enter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q <= PW_RUN;
    end else if (hw_stby) begin
      pw_q <= PW_RUN;
    end else if (pd_enter) begin
      pw_q <= PW_DOWN;
    end else if (pd_leave) begin
      pw_q <= PW_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hw_stby || pd_enter) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= f_accept(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (hw_stby || pd_enter) begin
      blk_q <= '0;
    end else if (wr_blk) begin
      blk_q <= wr_data;
    end
  end

  // R3: program and erase are never stored together
  p_pe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q.prog && ctrl_q.erase));

  // R9: entering power-down leaves both registers cleared
  p_pd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down) |-> (ctrl_q == '0) && (blk_q == '0));

  // R9: writes are ignored while powered down
  p_pd_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (down && pd_req && !hw_stby) |=> $stable(ctrl_q) && $stable(blk_q));

endmodule

// File: rtl/fg_event_mon.sv
module fg_event_mon (
  input  logic ev_fetch,
  input  logic ev_exc,
  input  logic ev_sleep,
  input  logic busy,
  output logic any_ev,
  output logic viol
);

  assign any_ev = ev_fetch | ev_exc | ev_sleep;
  assign viol   = any_ev & busy;

endmodule

// File: rtl/fg_err_latch.sv
module fg_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_stby,
  input  logic viol,
  output logic err_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (hw_stby) begin
      err_q <= 1'b0;
    end else if (viol) begin
      err_q <= 1'b1;
    end
  end

  // R4: a violation sets the flag at the next edge
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !hw_stby) |=> err_q);

  // R8: the flag holds until standby or reset
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !hw_stby) |=> err_q);

  // R5: the flag never rises without a violation
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && !viol) |=> !err_q);

  // R8: standby clears the flag
  p_stby_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> !err_q);

endmodule

// File: rtl/fg_permit.sv
module fg_permit
  import fg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  down,
  input  logic  hw_stby,
  input  logic  err,
  input  ctrl_t ctrl,
  output logic  ok_read,
  output logic  ok_verify,
  output logic  ok_prog,
  output logic  ok_erase,
  output logic  vfy_act,
  output logic  busy
);

  permit_t perm;

  assign perm      = f_permit(down, hw_stby, err, ctrl);
  assign ok_read   = perm.rd;
  assign ok_verify = perm.vf;
  assign ok_prog   = perm.pr;
  assign ok_erase  = perm.er;
  assign busy      = f_busy(perm);
  assign vfy_act   = perm.vf & (ctrl.pverify | ctrl.everify);

  // R7: the error state locks out reads, programming and erasing
  p_err_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ok_read && !ok_prog && !ok_erase);

  // R7: verify stays available in the error state
  p_err_verify_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !down && !hw_stby) |-> ok_verify);

  // R9: nothing is permitted while powered down
  p_pd_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    down |-> !(ok_read || ok_verify || ok_prog || ok_erase));

  // R8: nothing is permitted during hardware standby
  p_stby_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> !(ok_read || ok_verify || ok_prog || ok_erase));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             pd_req,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BLK_W-1:0] wr_data,
  input  logic             ev_fetch,
  input  logic             ev_exc,
  input  logic             ev_sleep,
  output logic             ok_read,
  output logic             ok_verify,
  output logic             ok_prog,
  output logic             ok_erase,
  output logic             vfy_act,
  output logic             err_flag,
  output logic [3:0]       ctrl_q,
  output logic [BLK_W-1:0] blk_q
);

  ctrl_t ctrl_s;
  logic  down_s;
  logic  busy_s;
  logic  any_ev_s;
  logic  viol_s;
  logic  err_s;

  if (BLK_W < CTRL_W) begin : g_bad_width
    initial $error("BLK_W must be at least CTRL_W");
  end

  fg_ctrl_regs #(.BLK_W(BLK_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_stby (hw_stby),
    .pd_req  (pd_req),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_s),
    .blk_q   (blk_q),
    .down    (down_s)
  );

  fg_event_mon u_evmon (
    .ev_fetch (ev_fetch),
    .ev_exc   (ev_exc),
    .ev_sleep (ev_sleep),
    .busy     (busy_s),
    .any_ev   (any_ev_s),
    .viol     (viol_s)
  );

  fg_err_latch u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_stby (hw_stby),
    .viol    (viol_s),
    .err_q   (err_s)
  );

  fg_permit u_perm (
    .clk       (clk),
    .rst_n     (rst_n),
    .down      (down_s),
    .hw_stby   (hw_stby),
    .err       (err_s),
    .ctrl      (ctrl_s),
    .ok_read   (ok_read),
    .ok_verify (ok_verify),
    .ok_prog   (ok_prog),
    .ok_erase  (ok_erase),
    .vfy_act   (vfy_act),
    .busy      (busy_s)
  );

  assign err_flag = err_s;
  assign ctrl_q   = ctrl_s;

  // R4: the abort is visible in the first cycle the flag reads 1
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !ok_prog && !ok_erase);

  // R6: the flag rising on its own leaves the registers as they were
  p_keep_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_flag) && !$past(wr_en) && !$past(pd_req) && !$past(hw_stby))
      |-> (ctrl_q == $past(ctrl_q)) && (blk_q == $past(blk_q)));

  // R11: events during power-down are harmless
  p_pd_events_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (down_s && any_ev_s && !err_flag) |=> !err_flag);

endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;

  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_stby = 1'b0;
  logic          pd_req = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [BW-1:0] wr_data = '0;
  logic          ev_fetch = 1'b0;
  logic          ev_exc = 1'b0;
  logic          ev_sleep = 1'b0;
  logic          ok_read, ok_verify, ok_prog, ok_erase, vfy_act, err_flag;
  logic [3:0]    ctrl_q;
  logic [BW-1:0] blk_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_guard #(.BLK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .pd_req(pd_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ev_fetch(ev_fetch), .ev_exc(ev_exc), .ev_sleep(ev_sleep),
    .ok_read(ok_read), .ok_verify(ok_verify), .ok_prog(ok_prog),
    .ok_erase(ok_erase), .vfy_act(vfy_act), .err_flag(err_flag),
    .ctrl_q(ctrl_q), .blk_q(blk_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected stored mode value: program clears a simultaneous erase
  function automatic int exp_mode(input int v);
    return ((v & 1) != 0) ? (v & 13) : v;
  endfunction

  task automatic wr(input bit sel, input int d);
    wr_en = 1'b1; wr_sel = sel; wr_data = BW'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic fire(input int k);
    ev_fetch = (k == 0); ev_exc = (k == 1); ev_sleep = (k == 2);
    tick();
    ev_fetch = 1'b0; ev_exc = 1'b0; ev_sleep = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic do_stby();
    hw_stby = 1'b1;
    tick();
    chk("R8 stby blocks read", int'(ok_read), 0);
    chk("R8 stby blocks verify", int'(ok_verify), 0);
    hw_stby = 1'b0;
    tick();
  endtask

  task automatic chk_normal(input string tag, input int m);
    chk({tag, " ctrl_q"}, int'(ctrl_q), m);
    chk({tag, " ok_prog"}, int'(ok_prog), m & 1);
    chk({tag, " ok_erase"}, int'(ok_erase), (m >> 1) & 1);
    chk({tag, " ok_read"}, int'(ok_read), 1);
    chk({tag, " ok_verify"}, int'(ok_verify), 1);
    chk({tag, " vfy_act"}, int'(vfy_act), ((m >> 2) != 0) ? 1 : 0);
  endtask

  initial begin
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 err", int'(err_flag), 0);
    chk("R1 ctrl", int'(ctrl_q), 0);
    chk("R1 blk", int'(blk_q), 0);
    chk("R1 read", int'(ok_read), 1);
    chk("R1 verify", int'(ok_verify), 1);
    chk("R1 prog", int'(ok_prog), 0);
    chk("R1 erase", int'(ok_erase), 0);

    // R2 block-enable register
    wr(1'b1, 8'h5A);
    chk("R2 blk write", int'(blk_q), 8'h5A);
    chk("R2 blk leaves ctrl", int'(ctrl_q), 0);

    // sweep: every mode value against every event kind
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 3; k++) begin
        int m;
        int busy;
        m = exp_mode(v);
        busy = ((m & 3) != 0) ? 1 : 0;
        wr(1'b1, v * 3 + k);
        wr(1'b0, v);
        chk_normal((v == 3) ? "R3 both" : "R2 mode", m);
        fire(k);
        chk(busy != 0 ? "R4 event sets err" : "R5 event idle", int'(err_flag), busy);
        chk("R4 abort prog", int'(ok_prog), busy != 0 ? 0 : (m & 1));
        chk("R4 abort erase", int'(ok_erase), busy != 0 ? 0 : ((m >> 1) & 1));
        chk("R6 ctrl kept", int'(ctrl_q), m);
        chk("R6 blk kept", int'(blk_q), (v * 3 + k) & 255);
        if (busy != 0) begin
          for (int r = 1; r < 16; r++) begin
            wr(1'b0, r);
            chk("R7 ctrl writable", int'(ctrl_q), exp_mode(r));
            chk("R7 no prog", int'(ok_prog), 0);
            chk("R7 no erase", int'(ok_erase), 0);
            chk("R7 no read", int'(ok_read), 0);
            chk("R7 verify ok", int'(ok_verify), 1);
            chk("R7 vfy_act", int'(vfy_act), ((r >> 2) != 0) ? 1 : 0);
          end
          fire((k + 1) % 3);
          chk("R8 err sticky", int'(err_flag), 1);
          if (((v + k) & 1) != 0) do_stby(); else do_reset();
          chk("R8 err cleared", int'(err_flag), 0);
          chk("R8 ctrl cleared", int'(ctrl_q), 0);
          chk("R8 blk cleared", int'(blk_q), 0);
          chk("R8 read back", int'(ok_read), 1);
        end
      end
    end

    // power-down from normal operation
    do_reset();
    wr(1'b1, 8'hA5);
    wr(1'b0, 5);
    pd_req = 1'b1;
    tick();
    chk("R9 ctrl cleared", int'(ctrl_q), 0);
    chk("R9 blk cleared", int'(blk_q), 0);
    chk("R9 err kept 0", int'(err_flag), 0);
    chk("R9 read blocked", int'(ok_read), 0);
    chk("R9 verify blocked", int'(ok_verify), 0);
    wr(1'b0, 1);
    wr(1'b1, 8'hFF);
    chk("R9 write ignored ctrl", int'(ctrl_q), 0);
    chk("R9 write ignored blk", int'(blk_q), 0);
    chk("R9 prog blocked", int'(ok_prog), 0);
    for (int k = 0; k < 3; k++) begin
      fire(k);
      chk("R11 pd event", int'(err_flag), 0);
    end
    pd_req = 1'b0;
    tick();
    chk("R10 normal read", int'(ok_read), 1);
    chk("R10 normal verify", int'(ok_verify), 1);
    chk("R10 err 0", int'(err_flag), 0);

    // power-down from the error state
    wr(1'b0, 2);
    fire(1);
    chk("R4 erase abort", int'(err_flag), 1);
    wr(1'b1, 8'h3C);
    pd_req = 1'b1;
    tick();
    chk("R9 err kept 1", int'(err_flag), 1);
    chk("R9 ctrl cleared err", int'(ctrl_q), 0);
    chk("R9 blk cleared err", int'(blk_q), 0);
    chk("R9 verify blocked err", int'(ok_verify), 0);
    fire(2);
    chk("R11 pd event err", int'(err_flag), 1);
    pd_req = 1'b0;
    tick();
    chk("R10 err state read", int'(ok_read), 0);
    chk("R10 err state verify", int'(ok_verify), 1);
    chk("R10 err flag", int'(err_flag), 1);
    wr(1'b0, 1);
    chk("R10 prog locked", int'(ok_prog), 0);
    do_stby();
    chk("R8 stby clears err", int'(err_flag), 0);
    chk("R8 stby read", int'(ok_read), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule